// File: doc/BRIEF.md
# Four-Bit Framed Code Detector

This block watches a one-bit serial stream and cuts it into back-to-back frames of four bits, starting with the first bit after reset. While the last bit of a frame is on the input, it reports whether the frame is one of two fixed codes. The match output is a Mealy output, so it depends on that last bit directly and is valid in the same cycle. At the end of every frame the machine returns to its start state, whatever the bits were. A pattern that spans two frames is therefore never reported.

Internally a minimized seven-state machine does the work. Prefixes that can still reach a code share states. After two bits, "01" and "10" share one state. After three bits, "010" and "100" share one state. Every prefix that can no longer match falls into one of two dead states, which do nothing but count out the rest of the frame. A frame-end strobe marks the fourth bit of every frame, so downstream logic can tell a "no match" verdict from a mid-frame bit.

Top module: `frame_code_detector`

## Requirements
- R1: A synchronous reset, sampled high on a rising edge, puts the machine in its start state. In the cycle after reset is released, both frame_end and match read 0 whatever din is, and the next sampled bit is the first bit of a frame.
- R2: frame_end is 1 on exactly every fourth sampled bit after reset (bits 4, 8, 12, ...) and 0 on all other bits.
- R3: Bits are compared in arrival order, first bit leftmost. When a frame reads 0101, match is 1 while its fourth bit is on din.
- R4: When a frame reads 1001, match is 1 while its fourth bit is on din.
- R5: On the fourth bit of any frame other than 0101 and 1001, match is 0. This includes the near misses 0100, 1000, 0111, 1101 and 0001.
- R6: match is 0 on every bit where frame_end is 0.
- R7: Frames never overlap. A code whose bits straddle a frame boundary, such as 1010 followed by 1000, or 1110 followed by 0111, gives match 0.
- R8: After the fourth bit of a frame the machine is back in its start state, whatever that frame held. Detection in the next frame depends only on that frame's bits.
- R9: A reset asserted part-way through a frame discards the partial frame. The frame boundary then realigns, so the first bit after reset starts a new frame.
- R10: During the fourth bit of a frame whose first three bits are 010 or 100, match follows din within the same cycle: 0 while din is 0, and 1 once din turns 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, one per clock |
| frame_end | output | 1 | High while the fourth bit of a frame is being sampled |
| match | output | 1 | High on the fourth bit when the frame equals one of the two codes |

## Verification
Two situations are hard to reach from the ports. The first is a same-cycle change of the Mealy output. To produce it, the bench drives the last bit of a live frame low, lets the output settle, and then raises the bit before the clock edge. It checks match both before and after the change. The second is the realignment after a reset that arrives mid-frame. The bench abandons a frame after two bits and then expects a code to be detected on the new alignment. Frames whose codes straddle a boundary, and a sweep of all sixteen frame values, separate true framing from sliding-window detection.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

    localparam int FRAME_BITS = 4;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam logic [FRAME_BITS-1:0] CODE_A = 4'b0101;
    localparam logic [FRAME_BITS-1:0] CODE_B = 4'b1001;

    // Minimized state set; LIVE states can still reach a code, DEAD ones cannot.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GOT0  = 3'd1,
        ST_GOT1  = 3'd2,
        ST_LIVE2 = 3'd3,
        ST_LIVE3 = 3'd4,
        ST_DEAD2 = 3'd5,
        ST_DEAD3 = 3'd6
    } state_e;

    typedef struct packed {
        state_e nxt;
        logic   fend;
        logic   hit;
    } step_t;

    function automatic logic is_last(state_e s);
        return (s == ST_LIVE3) || (s == ST_DEAD3);
    endfunction

    // Both codes end in the same bit, so a live third-bit prefix hits on it.
    function automatic step_t step(state_e s, logic b);
        step_t r;
        r.nxt  = ST_IDLE;
        r.fend = is_last(s);
        r.hit  = 1'b0;
        case (s)
            ST_IDLE:  r.nxt = b ? ST_GOT1 : ST_GOT0;
            ST_GOT0:  r.nxt = b ? ST_LIVE2 : ST_DEAD2;
            ST_GOT1:  r.nxt = b ? ST_DEAD2 : ST_LIVE2;
            ST_LIVE2: r.nxt = b ? ST_DEAD3 : ST_LIVE3;
            ST_DEAD2: r.nxt = ST_DEAD3;
            ST_LIVE3: begin
                r.nxt = ST_IDLE;
                r.hit = (b == CODE_A[0]);
            end
            ST_DEAD3: r.nxt = ST_IDLE;
            default:  r.nxt = ST_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcd_next.sv
`timescale 1ns/1ps
module fcd_next
    import fcd_pkg::*;
(
    input  state_e cur,
    input  logic   din,
    output step_t  res
);
    always_comb begin
        res = step(cur, din);
    end
endmodule

// File: rtl/fcd_state.sv
`timescale 1ns/1ps
module fcd_state
    import fcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt,
    output state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/frame_code_detector.sv
`timescale 1ns/1ps
module frame_code_detector
    import fcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic frame_end,
    output logic match
);
    state_e st;
    step_t  nx;

    fcd_state u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nx.nxt),
        .cur (st)
    );

    fcd_next u_next (
        .cur (st),
        .din (din),
        .res (nx)
    );

    assign frame_end = nx.fend;
    assign match     = nx.hit;
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker
    import fcd_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   din,
    input logic   frame_end,
    input logic   match,
    input state_e st
);
    logic [POS_W-1:0]      ph;
    logic [FRAME_BITS-2:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            hist <= '0;
        end else begin
            ph   <= ph + 1'b1;
            hist <= {hist[FRAME_BITS-3:0], din};
        end
    end

    p_reset_start_r1: assert property (@(posedge clk) rst |=> (st == ST_IDLE));

    p_frame_phase_r2: assert property (@(posedge clk) disable iff (rst)
        frame_end == (ph == POS_W'(FRAME_BITS-1)));

    // R3 and R4: match agrees with the four bits of the aligned frame
    p_code_hit_r3: assert property (@(posedge clk) disable iff (rst)
        match == (frame_end && (({hist, din} == CODE_A) || ({hist, din} == CODE_B))));

    p_match_in_end_r6: assert property (@(posedge clk) disable iff (rst)
        match |-> frame_end);

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (st == ST_IDLE));
endmodule

bind frame_code_detector fcd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .frame_end (frame_end),
    .match     (match),
    .st        (st)
);

// File: tb/sim_frame_code_detector.sv
`timescale 1ns/1ps
module sim_frame_code_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic frame_end, match;

    always #2.5 clk = ~clk;

    frame_code_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .frame_end (frame_end),
        .match     (match)
    );

    typedef struct {
        logic  fe;
        logic  m;
        string req;
    } exp_t;

    exp_t     q[$];
    exp_t     got;
    int       n_chk = 0;
    int       n_fail = 0;
    int       pos = 0;
    logic [2:0] pre = 3'b000;
    string    tag = "";
    bit       done = 1'b0;

    task automatic check(string r, logic fe_a, logic m_a, logic fe_e, logic m_e);
        n_chk++;
        if (fe_a !== fe_e || m_a !== m_e) begin
            n_fail++;
            $display("FAIL %s: frame_end/match = %b%b, expected %b%b", r, fe_a, m_a, fe_e, m_e);
        end
    endtask

    function automatic exp_t predict(logic b);
        exp_t e;
        logic [3:0] f;
        f     = {pre, b};
        e.fe  = (pos == 3);
        e.m   = e.fe && (f == 4'b0101 || f == 4'b1001);
        if (tag != "")   e.req = tag;
        else if (e.m)    e.req = (f == 4'b0101) ? "R3" : "R4";
        else if (e.fe)   e.req = "R5";
        else             e.req = "R6";
        return e;
    endfunction

    task automatic commit(logic b);
        pre = {pre[1:0], b};
        pos = (pos + 1) % 4;
    endtask

    task automatic send(logic b);
        @(negedge clk);
        din = b;
        q.push_back(predict(b));
        commit(b);
    endtask

    task automatic send_frame(logic [3:0] f);
        for (int i = 3; i >= 0; i--) send(f[i]);
    endtask

    // R1 / R9: reset over two edges, released between edges
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        pos = 0;
        pre = 3'b000;
        check("R1", frame_end, match, 1'b0, 1'b0);
    endtask

    // R10: drive 0 on a live fourth bit, then raise it within the same cycle
    task automatic mealy_flip();
        @(negedge clk);
        din = 1'b0;
        tag = "R10";
        q.push_back(predict(1'b0));
        tag = "";
        #1.5 din = 1'b1;
        #0.5 check("R10", frame_end, match, 1'b1, 1'b1);
        commit(1'b1);
    endtask

    // Scoreboard monitor: compares one expected item per sampled bit
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            got = q.pop_front();
            check(got.req, frame_end, match, got.fe, got.m);
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R3 R4 R5: mixed frame sequence
        send_frame(4'b0101); send_frame(4'b0001);
        send_frame(4'b0010); send_frame(4'b0000);
        send_frame(4'b1001); send_frame(4'b0001);
        send_frame(4'b0100); send_frame(4'b0000);

        // R5: near misses
        send_frame(4'b1000); send_frame(4'b0111);
        send_frame(4'b1101); send_frame(4'b1011);

        // R7: codes straddling frame boundaries
        tag = "R7";
        send_frame(4'b1010); send_frame(4'b1000);
        send_frame(4'b1110); send_frame(4'b0111);
        tag = "";

        // R8: a code right after dead frames and after a hit
        tag = "R8";
        send_frame(4'b1111); send_frame(4'b1001);
        send_frame(4'b0101); send_frame(4'b0101);
        tag = "";

        // R2 R5: every frame value
        for (int v = 0; v < 16; v++) send_frame(4'(v));

        // R10: same-cycle response to the last bit, both live prefixes
        send(1'b0); send(1'b1); send(1'b0); mealy_flip();
        send(1'b1); send(1'b0); send(1'b0); mealy_flip();

        // R9: reset two bits into a frame, then a code on the new alignment
        send(1'b0); send(1'b1);
        @(negedge clk);
        do_reset();
        tag = "R9";
        send_frame(4'b1001);
        send(1'b0); send(1'b1); send(1'b0);
        @(negedge clk);
        do_reset();
        send_frame(4'b0101);
        tag = "";

        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule